// File: doc/BRIEF.md
# Programmable SPI Master Word Shifter

This block is a single-packet SPI master. A host sets the configuration inputs and a 16-bit transmit word, then raises `start` for one cycle while the block is idle. The block samples the configuration at that moment and keeps it for the whole packet. It asserts chip select, waits a programmable lead-in time and then shifts one packet on SCLK. The packet is 8 or 16 bits, sent with the most or the least significant bit first. After the last bit the block releases chip select, waits an inter-packet gap and then gives a one-cycle `done` pulse. The received word is on `rx_data` when `done` is high.

Three bus forms are available:
- a full-duplex single lane that transmits on lane 0 and receives on lane 1;
- a 2-lane half-duplex form that moves two bits per SCLK period, with a selectable lane order;
- a 3-wire half-duplex form that uses lane 0 in both directions.

All four SCLK polarity/phase modes are supported. Chip-select polarity is programmable. The data lanes can be released to high impedance whenever they carry nothing. The receive capture point follows a selectable SCLK edge and can be delayed by 0, 1 or 2 system clocks to absorb round-trip delay.

The control is one state machine with these states:
- ST_IDLE: waits for `start`.
- ST_LEAD: chip select is active; counts the lead-in time.
- ST_SHIFT: generates the SCLK edges.
- ST_TAIL: holds chip select for one half period plus two cycles after the last edge, so that a delayed capture can complete.
- ST_GAP: chip select is inactive; counts the inter-packet gap.
- ST_DONE: one cycle that produces the `done` pulse.

The transitions are:
- ST_IDLE to ST_LEAD on `start`.
- ST_LEAD to ST_SHIFT when the lead counter expires.
- ST_SHIFT to ST_TAIL on the last SCLK edge.
- ST_TAIL to ST_GAP when the tail counter expires.
- ST_GAP to ST_DONE when the gap counter expires.
- ST_DONE to ST_IDLE unconditionally.

Top module: `spi_shift_master`

## Requirements
- R1: After reset `busy` and `done` are 0, `cs` is 1 (active-low default), `sclk` is 0 (mode 0 default), LSB-first order applies, and `sd_oe` is 2'b01 (lanes driven by default).
- R2: `start` in idle makes `busy` 1 from the next cycle; a `start` while busy is ignored, and no further packet follows the `done` pulse.
- R3: `cfg_mode[1]` is the SCLK idle level and `cfg_mode[0]` the phase. With phase 0 the first bit is valid before the first edge and data changes on even edges. With phase 1 data changes on odd edges.
- R4: `cfg_msb_first`=1 sends and assembles bit 7 (or 15) first; 0 sends bit 0 first.
- R5: `cfg_len16`=1 moves 16 bits, 0 moves the low 8 bits. The number of SCLK edges is twice the number of beats.
- R6: `cfg_cs_high`=1 makes `cs` active high, otherwise active low; `cs` is active from the cycle after `start`.
- R7: The first SCLK edge comes `cfg_lead`+H+1 cycles after `cs` goes active, and later edges come every H cycles, where H = `cfg_half`, or 1 when `cfg_half` is 0.
- R8: `cs` goes inactive H+2 cycles after the last edge. `done` is high for exactly one cycle, `cfg_gap`+1 cycles after that, and `busy` is 0 in the `done` cycle.
- R9: `cfg_bus`=2'b01 selects 2-lane half duplex with half the beats. With `cfg_lane_swap`=0 the earlier bit of each pair goes on lane 1; with 1 it goes on lane 0.
- R10: `cfg_bus`=2'b10 selects 3-wire mode on lane 0 only, and `cfg_rx_dir`=1 releases the lane and reads `sd_in[0]`. `cfg_bus`=2'b00 drives lane 0 and reads `sd_in[1]`. In half-duplex receive `sd_oe` is 2'b00 while `cs` is active.
- R11: With `cfg_hiz`=1, `sd_oe` is 2'b00 whenever `cs` is inactive. With 0, the lanes of the bus form stay driven (2'b01, or 2'b11 in 2-lane mode).
- R12: Received bits are captured on the rising SCLK edge (`cfg_lat_fall`=0) or the falling edge (1), delayed by `cfg_lat_shift` system clocks (0 to 2; 3 acts as 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle packet request, accepted in idle |
| tx_data | input | 16 | Word to transmit |
| cfg_mode | input | 2 | SCLK mode: bit 1 idle level, bit 0 phase |
| cfg_msb_first | input | 1 | 1 = MSB first, 0 = LSB first |
| cfg_cs_high | input | 1 | 1 = chip select active high |
| cfg_len16 | input | 1 | 1 = 16-bit packet, 0 = 8-bit |
| cfg_bus | input | 2 | 00 full duplex, 01 2-lane, 10 3-wire |
| cfg_lane_swap | input | 1 | 2-lane order: 1 = lane 0 first |
| cfg_rx_dir | input | 1 | Half-duplex direction: 1 = receive |
| cfg_hiz | input | 1 | Release lanes when nothing is driven |
| cfg_lat_shift | input | 2 | Capture delay in system clocks |
| cfg_lat_fall | input | 1 | 1 = capture on falling SCLK edge |
| cfg_half | input | DIV_W | SCLK half period in system clocks |
| cfg_lead | input | DLY_W | Chip-select-to-first-edge delay |
| cfg_gap | input | DLY_W | Inter-packet gap |
| sd_in | input | 2 | Lane input values |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| cs | output | 1 | Chip select |
| sd_out | output | 2 | Lane output values |
| sd_oe | output | 2 | Lane output enables |
| rx_data | output | 16 | Received word |

## Verification
The bench builds the block with its default parameters, DIV_W = 8 and DLY_W = 16. This makes the whole half-period and delay ranges legal, but the bench keeps the half periods between 0 and 5 and the delays below 8, so that every packet form and mode combination fits in a short run. Its slave model feeds the lanes through a delay of 0 to 2 cycles that matches the capture shift. With a half period of 2 this makes a wrong capture delay read the wrong beat. A directed zero half-period case covers the clamp to one cycle.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP,
        ST_DONE
    } state_e;

    localparam logic [1:0] BUS_FULL  = 2'b00;
    localparam logic [1:0] BUS_WIDE  = 2'b01;
    localparam logic [1:0] BUS_3WIRE = 2'b10;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       msb_first;
        logic       cs_high;
        logic       len16;
        logic [1:0] bus;
        logic       lane_swap;
        logic       rx_dir;
        logic       hiz;
        logic [1:0] lat_shift;
        logic       lat_fall;
    } cfg_t;

    // Word bit carried by position 'seq' of the serial sequence.
    function automatic logic [3:0] bit_pos(input logic [4:0] seq,
                                           input logic       len16,
                                           input logic       msb);
        logic [4:0] nb;
        nb = len16 ? 5'd16 : 5'd8;
        return msb ? 4'(nb - 5'd1 - seq) : seq[3:0];
    endfunction

endpackage

// File: rtl/spi_shift_timer.sv
module spi_shift_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/spi_shift_lane_map.sv
module spi_shift_lane_map
    import spi_shift_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [3:0]        beat,
    input  logic [1:0]        bus,
    input  logic              lane_swap,
    input  logic              msb_first,
    input  logic              len16,
    output logic [1:0]        lanes
);
    logic first_bit;
    logic second_bit;
    logic single_bit;

    always_comb begin
        first_bit  = word[bit_pos({beat, 1'b0}, len16, msb_first)];
        second_bit = word[bit_pos({beat, 1'b1}, len16, msb_first)];
        single_bit = word[bit_pos({1'b0, beat}, len16, msb_first)];
        if (bus == BUS_WIDE) begin
            lanes = lane_swap ? {second_bit, first_bit} : {first_bit, second_bit};
        end else begin
            lanes = {1'b0, single_bit};
        end
    end
endmodule

// File: rtl/spi_shift_rx.sv
module spi_shift_rx
    import spi_shift_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              strobe,
    input  logic [1:0]        lat_shift,
    input  logic [1:0]        bus,
    input  logic              lane_swap,
    input  logic              msb_first,
    input  logic              len16,
    input  logic [1:0]        sd_in,
    output logic [WORD_W-1:0] rx_word
);
    logic [1:0] strobe_d;
    logic [3:0] rx_beat;
    logic       cap;

    always_comb begin
        unique case (lat_shift)
            2'd0:    cap = strobe;
            2'd1:    cap = strobe_d[0];
            default: cap = strobe_d[1];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_d <= '0;
            rx_beat  <= '0;
            rx_word  <= '0;
        end else begin
            strobe_d <= {strobe_d[0], strobe};
            if (clr) begin
                rx_beat <= '0;
                rx_word <= '0;
            end else if (cap) begin
                rx_beat <= rx_beat + 1'b1;
                if (bus == BUS_WIDE) begin
                    rx_word[bit_pos({rx_beat, 1'b0}, len16, msb_first)] <= lane_swap ? sd_in[0] : sd_in[1];
                    rx_word[bit_pos({rx_beat, 1'b1}, len16, msb_first)] <= lane_swap ? sd_in[1] : sd_in[0];
                end else if (bus == BUS_3WIRE) begin
                    rx_word[bit_pos({1'b0, rx_beat}, len16, msb_first)] <= sd_in[0];
                end else begin
                    rx_word[bit_pos({1'b0, rx_beat}, len16, msb_first)] <= sd_in[1];
                end
            end
        end
    end
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
    import spi_shift_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DLY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_data,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_msb_first,
    input  logic              cfg_cs_high,
    input  logic              cfg_len16,
    input  logic [1:0]        cfg_bus,
    input  logic              cfg_lane_swap,
    input  logic              cfg_rx_dir,
    input  logic              cfg_hiz,
    input  logic [1:0]        cfg_lat_shift,
    input  logic              cfg_lat_fall,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic [DLY_W-1:0]  cfg_lead,
    input  logic [DLY_W-1:0]  cfg_gap,
    input  logic [1:0]        sd_in,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              cs,
    output logic [1:0]        sd_out,
    output logic [1:0]        sd_oe,
    output logic [WORD_W-1:0] rx_data
);
    localparam int TMR_W = (DIV_W + 1 > DLY_W) ? DIV_W + 1 : DLY_W;

    state_e             state, state_nx;
    cfg_t               cfg_in, cfg_q;
    logic [WORD_W-1:0]  tx_q;
    logic [DIV_W-1:0]   half_q, half_eff;
    logic [DLY_W-1:0]   gap_q;
    logic [5:0]         edge_cnt, edge_k, edges_total;
    logic [3:0]         beat;
    logic               sclk_q, cs_act;
    logic               tmr_load, tmr_zero;
    logic [TMR_W-1:0]   tmr_val;
    logic               edge_now, last_edge, launch, strobe, accept;
    logic               half_dup, tx_drv, wide;
    logic [1:0]         lanes;

    always_comb begin
        cfg_in = '{cpol: cfg_mode[1], cpha: cfg_mode[0], msb_first: cfg_msb_first,
                   cs_high: cfg_cs_high, len16: cfg_len16, bus: cfg_bus,
                   lane_swap: cfg_lane_swap, rx_dir: cfg_rx_dir, hiz: cfg_hiz,
                   lat_shift: cfg_lat_shift, lat_fall: cfg_lat_fall};
    end

    assign accept      = (state == ST_IDLE) && start;
    assign half_eff    = (half_q == '0) ? DIV_W'(1) : half_q;
    assign wide        = (cfg_q.bus == BUS_WIDE);
    assign edges_total = wide ? (cfg_q.len16 ? 6'd16 : 6'd8) : (cfg_q.len16 ? 6'd32 : 6'd16);
    assign edge_now    = (state == ST_SHIFT) && tmr_zero;
    assign edge_k      = edge_cnt + 6'd1;
    assign last_edge   = (edge_k == edges_total);
    assign launch      = edge_now && (cfg_q.cpha ? edge_k[0] : (!edge_k[0] && !last_edge));
    assign strobe      = edge_now && ((~sclk_q) == (~cfg_q.lat_fall));

    // Next state and timer reload
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (start) begin
                state_nx = ST_LEAD;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(cfg_lead);
            end
            ST_LEAD: if (tmr_zero) begin
                state_nx = ST_SHIFT;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(half_eff) - 1'b1;
            end
            ST_SHIFT: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (last_edge) begin
                    state_nx = ST_TAIL;
                    tmr_val  = TMR_W'(half_eff) + 1'b1;
                end else begin
                    tmr_val  = TMR_W'(half_eff) - 1'b1;
                end
            end
            ST_TAIL: if (tmr_zero) begin
                state_nx = ST_GAP;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(gap_q);
            end
            ST_GAP:  if (tmr_zero) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            tx_q     <= '0;
            half_q   <= '0;
            gap_q    <= '0;
            sclk_q   <= 1'b0;
            cs_act   <= 1'b0;
            edge_cnt <= '0;
            beat     <= '0;
        end else if (accept) begin
            cfg_q    <= cfg_in;
            tx_q     <= tx_data;
            half_q   <= cfg_half;
            gap_q    <= cfg_gap;
            sclk_q   <= cfg_in.cpol;
            cs_act   <= 1'b1;
            edge_cnt <= '0;
            beat     <= '0;
        end else if (edge_now) begin
            sclk_q   <= ~sclk_q;
            edge_cnt <= edge_k;
            if (launch) beat <= edge_k[4:1];
        end else if ((state == ST_TAIL) && tmr_zero) begin
            cs_act   <= 1'b0;
            sclk_q   <= cfg_q.cpol;
        end
    end

    spi_shift_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    spi_shift_lane_map u_map (
        .word(tx_q), .beat(beat), .bus(cfg_q.bus), .lane_swap(cfg_q.lane_swap),
        .msb_first(cfg_q.msb_first), .len16(cfg_q.len16), .lanes(lanes)
    );

    spi_shift_rx u_rx (
        .clk(clk), .rst_n(rst_n), .clr(accept), .strobe(strobe),
        .lat_shift(cfg_q.lat_shift), .bus(cfg_q.bus), .lane_swap(cfg_q.lane_swap),
        .msb_first(cfg_q.msb_first), .len16(cfg_q.len16), .sd_in(sd_in), .rx_word(rx_data)
    );

    assign half_dup = (cfg_q.bus == BUS_WIDE) || (cfg_q.bus == BUS_3WIRE);
    assign tx_drv   = !half_dup || !cfg_q.rx_dir;

    assign busy     = (state != ST_IDLE) && (state != ST_DONE);
    assign done     = (state == ST_DONE);
    assign sclk     = sclk_q;
    assign cs       = cfg_q.cs_high ? cs_act : ~cs_act;
    assign sd_out   = (cs_act && tx_drv) ? lanes : 2'b00;
    assign sd_oe[0] = cs_act ? tx_drv : !cfg_q.hiz;
    assign sd_oe[1] = wide && (cs_act ? tx_drv : !cfg_q.hiz);
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk
    import spi_shift_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       sclk,
    input logic [1:0] sd_oe,
    input state_e     state,
    input logic       cs_act,
    input cfg_t       cfg_q,
    input logic [5:0] edge_cnt
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> busy);

    p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_cs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_DONE) |-> !cs_act);

    p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> ($past(state) == ST_SHIFT || $past(state) == ST_IDLE
                            || $past(state) == ST_TAIL));

    p_rx_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && cfg_q.rx_dir && (cfg_q.bus == BUS_WIDE || cfg_q.bus == BUS_3WIRE))
            |-> sd_oe == 2'b00);

    p_hiz_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && cfg_q.hiz) |-> sd_oe == 2'b00);

    p_edge_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= 6'd32);
endmodule

bind spi_shift_master spi_shift_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .sclk(sclk), .sd_oe(sd_oe), .state(state), .cs_act(cs_act),
    .cfg_q(cfg_q), .edge_cnt(edge_cnt)
);

// File: tb/spi_shift_master_tb.sv
`timescale 1ns/1ps
module spi_shift_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tx_data = '0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_msb_first = 1'b0, cfg_cs_high = 1'b0, cfg_len16 = 1'b0;
    logic [1:0]  cfg_bus = '0;
    logic        cfg_lane_swap = 1'b0, cfg_rx_dir = 1'b0, cfg_hiz = 1'b0;
    logic [1:0]  cfg_lat_shift = '0;
    logic        cfg_lat_fall = 1'b0;
    logic [7:0]  cfg_half = 8'd2;
    logic [15:0] cfg_lead = '0, cfg_gap = '0;
    logic [1:0]  sd_in;
    logic        busy, done, sclk, cs;
    logic [1:0]  sd_out, sd_oe;
    logic [15:0] rx_data;

    logic [1:0]  ideal = '0, p1 = '0, p2 = '0;
    int          dly = 0;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    always_comb sd_in = (dly == 0) ? ideal : (dly == 1) ? p1 : p2;

    spi_shift_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
        .cfg_mode(cfg_mode), .cfg_msb_first(cfg_msb_first), .cfg_cs_high(cfg_cs_high),
        .cfg_len16(cfg_len16), .cfg_bus(cfg_bus), .cfg_lane_swap(cfg_lane_swap),
        .cfg_rx_dir(cfg_rx_dir), .cfg_hiz(cfg_hiz), .cfg_lat_shift(cfg_lat_shift),
        .cfg_lat_fall(cfg_lat_fall), .cfg_half(cfg_half), .cfg_lead(cfg_lead),
        .cfg_gap(cfg_gap), .sd_in(sd_in), .busy(busy), .done(done), .sclk(sclk),
        .cs(cs), .sd_out(sd_out), .sd_oe(sd_oe), .rx_data(rx_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bpos(input int seq, input bit len16, input bit msb);
        int nb = len16 ? 16 : 8;
        return msb ? nb - 1 - seq : seq;
    endfunction

    function automatic logic [1:0] slave_bits(input logic [15:0] w, input int b);
        logic f, s;
        if (cfg_bus == 2'b01) begin
            f = w[bpos(2*b, cfg_len16, cfg_msb_first)];
            s = w[bpos(2*b+1, cfg_len16, cfg_msb_first)];
            return cfg_lane_swap ? {s, f} : {f, s};
        end else if (cfg_bus == 2'b10) begin
            return {1'b0, w[bpos(b, cfg_len16, cfg_msb_first)]};
        end
        return {w[bpos(b, cfg_len16, cfg_msb_first)], 1'b0};
    endfunction

    task automatic shift_line();
        p2 = p1;
        p1 = ideal;
    endtask

    task automatic run(input logic [15:0] tx, input logic [15:0] rxw, input logic [1:0] mode,
                       input bit msb, input bit csh, input bit len16, input logic [1:0] bus,
                       input bit swap, input bit rxd, input bit hiz, input int shift,
                       input logic [7:0] half, input logic [15:0] lead, input logic [15:0] gap,
                       input bit poke);
        int half_eff = (half == 0) ? 1 : int'(half);
        int beats = (len16 ? 16 : 8) / ((bus == 2'b01) ? 2 : 1);
        int cyc = 0, edges = 0, samples = 0, last_e = 0, cs_off = -1;
        bit prev, busy_bad = 0;
        logic [15:0] txw = '0, mask;
        logic [1:0] oe_exp;
        string rq;
        mask = len16 ? 16'hffff : 16'h00ff;
        tx_data = tx; cfg_mode = mode; cfg_msb_first = msb; cfg_cs_high = csh;
        cfg_len16 = len16; cfg_bus = bus; cfg_lane_swap = swap; cfg_rx_dir = rxd;
        cfg_hiz = hiz; cfg_lat_shift = 2'(shift); cfg_lat_fall = mode[1] ^ mode[0];
        cfg_half = half; cfg_lead = lead; cfg_gap = gap; dly = shift;
        start = 1'b1;
        shift_line();
        ideal = slave_bits(rxw, 0);
        @(negedge clk);
        start = 1'b0;
        shift_line();
        chk(cs == csh, "R6 cs active level", cs, csh);
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        chk(sclk == mode[1], "R3 sclk idle level", sclk, mode[1]);
        prev = sclk;
        oe_exp = (bus != 2'b00 && rxd) ? 2'b00 : (bus == 2'b01 ? 2'b11 : 2'b01);
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            shift_line();
            if (poke && cyc == 4) start = 1'b1;
            if (poke && cyc == 5) start = 1'b0;
            if (!done && !busy) busy_bad = 1;
            if (sclk != prev) begin
                edges++;
                prev = sclk;
                if (edges == 1)
                    chk(cyc == int'(lead) + half_eff + 1, "R7 lead to first edge", cyc, int'(lead) + half_eff + 1);
                else
                    chk(cyc - last_e == half_eff, "R7 edge spacing", cyc - last_e, half_eff);
                last_e = cyc;
                if (sclk == ~cfg_lat_fall) begin
                    rq = (bus == 2'b00) ? "R11 oe during packet" : "R10 oe during packet";
                    chk(sd_oe == oe_exp, rq, sd_oe, oe_exp);
                    if (bus == 2'b01) begin
                        txw[bpos(2*samples, len16, msb)]   = swap ? sd_out[0] : sd_out[1];
                        txw[bpos(2*samples+1, len16, msb)] = swap ? sd_out[1] : sd_out[0];
                    end else begin
                        txw[bpos(samples, len16, msb)] = sd_out[0];
                    end
                    samples++;
                end else if (samples < beats) begin
                    ideal = slave_bits(rxw, samples);
                end
            end
            if (cs != csh && cs_off < 0) begin
                cs_off = cyc;
                chk(cyc - last_e == half_eff + 2, "R8 cs release after last edge", cyc - last_e, half_eff + 2);
            end
        end
        chk(cyc - cs_off == int'(gap) + 1, "R8 gap to done", cyc - cs_off, int'(gap) + 1);
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);
        chk(edges == 2*beats, "R5 edge count", edges, 2*beats);
        if (!(bus != 2'b00 && rxd)) begin
            rq = (bus == 2'b01) ? "R9 lane data" : (bus == 2'b10) ? "R10 3-wire data" : "R4 tx order";
            chk(txw == (tx & mask), rq, txw, tx & mask);
        end
        if (bus == 2'b00 || rxd)
            chk(rx_data == (rxw & mask), "R12 received word", rx_data, rxw & mask);
        @(negedge clk);
        shift_line();
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        oe_exp = hiz ? 2'b00 : (bus == 2'b01 ? 2'b11 : 2'b01);
        chk(sd_oe == oe_exp, "R11 idle lane enables", sd_oe, oe_exp);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && !busy_bad, "R2 no extra packet and busy held", busy, 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset idle", {busy, done}, 0);
        chk(cs == 1'b1, "R1 reset cs inactive high", cs, 1);
        chk(sclk == 1'b0, "R1 reset sclk low", sclk, 0);
        chk(sd_oe == 2'b01, "R1 reset lane enables", sd_oe, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        // directed: each mode, both orders, both lengths
        run(16'hA5C3, 16'h3C5A, 2'd0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 8'd3, 16'd2, 16'd0, 0);
        run(16'hA5C3, 16'h1234, 2'd1, 1, 1, 1, 2'b00, 0, 0, 0, 0, 8'd2, 16'd0, 16'd3, 1);
        run(16'h8001, 16'hF00F, 2'd2, 1, 0, 1, 2'b00, 0, 0, 1, 1, 8'd3, 16'd1, 16'd1, 0);
        run(16'h00B4, 16'h0069, 2'd3, 0, 1, 0, 2'b00, 0, 0, 0, 2, 8'd2, 16'd4, 16'd2, 0);
        // 2-lane both orders, both directions
        run(16'hC3A5, 16'h5AA5, 2'd0, 1, 0, 1, 2'b01, 0, 0, 0, 0, 8'd2, 16'd0, 16'd0, 0);
        run(16'hC3A5, 16'h96E1, 2'd3, 0, 0, 1, 2'b01, 1, 1, 0, 2, 8'd2, 16'd1, 16'd1, 0);
        run(16'h0000, 16'h00D2, 2'd1, 1, 0, 0, 2'b01, 1, 1, 1, 1, 8'd2, 16'd2, 16'd0, 0);
        // 3-wire transmit and receive
        run(16'h5A3C, 16'h0000, 2'd0, 1, 0, 1, 2'b10, 0, 0, 0, 0, 8'd3, 16'd0, 16'd1, 0);
        run(16'h0000, 16'hBEEF, 2'd2, 0, 1, 1, 2'b10, 0, 1, 1, 2, 8'd2, 16'd3, 16'd0, 0);
        // zero half period acts as one cycle
        run(16'h00C5, 16'h003A, 2'd0, 1, 0, 0, 2'b00, 0, 0, 0, 0, 8'd0, 16'd0, 16'd0, 0);
        for (int i = 0; i < 40; i++) begin
            int sh = $urandom % 3;
            logic [7:0] hv = 8'(2 + $urandom % 4);
            run(16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 2'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom),
                sh, hv, 16'($urandom % 8), 16'($urandom % 6), 1'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule